// File: doc/BRIEF.md
# Rewindable Single-Clock FIFO

This block is a first-in first-out buffer with one clock, a write port and a read port. It adds a rewind strobe. The strobe moves the read side back to memory location zero, so that everything written since master reset can be read out again. The write side is left alone. The buffer suits a producer that may need to resend a short frame, such as a packet held for a possible retry. In that use the frame is written once and read as many times as needed. Retransmit is defined only while the total number of words written since master reset does not exceed the memory depth.

Two options are captured while master reset is held, and they stay fixed until the next master reset. The first is the read-port style. Standard style presents a word one cycle after a read request and shows an empty flag. Fall-through style places the head word on the output without a request and raises a ready flag. The second option is the rewind latency. Zero latency puts the word from location zero on the output at the rewind edge itself. Normal latency spends one recovery cycle first, and the word arrives on a later cycle.

The read controller is a two-state machine. In ST_RUN it performs normal reads and fall-through loads. ST_RECOVER is the recovery cycle of a normal-latency rewind. The transitions are:
- ST_RUN to ST_RECOVER on a rewind when normal latency is latched.
- ST_RECOVER back to ST_RUN on the next edge.
- ST_RECOVER to ST_RECOVER on a repeated rewind.
- ST_RUN to ST_RUN in every other case, including a zero-latency rewind.

Top module: `rewind_fifo`

## Requirements
- R1: While `mrst` is high at a clock edge, both pointers are cleared and `rd_data` becomes 0. After that edge `empty` is 1, `out_ready` is 0 and `full` is 0.
- R2: `sel_fwft` and `sel_rt_normal` are sampled only at edges where `mrst` is high. Changes on these inputs at other times have no effect on read style or rewind latency.
- R3: A word is stored only at an edge where `wr_en` is 1 and `full` is 0. `full` is 1 while DEPTH words are held in memory. A write presented while `full` is 1 is dropped.
- R4: In standard style (`sel_fwft`=0 at reset), `empty` is 1 when no word is held. A read at an edge where `empty` is 0 places the oldest word on `rd_data` after that edge. A read while `empty` is 1 leaves `rd_data` and the pointers unchanged.
- R5: In fall-through style (`sel_fwft`=1 at reset), the oldest word appears on `rd_data` with `out_ready`=1 one edge after it is available, without any read request. A read while `out_ready` is 1 advances to the next word, or drops `out_ready` when no word remains.
- R6: A rewind (`rewind`=1 at an edge) sets the read pointer to location 0. It leaves the write pointer and the stored words untouched, so words written afterwards still follow the existing ones.
- R7: Standard style, normal latency (`sel_rt_normal`=1): `empty` is 1 for the cycle after the rewind edge. Reads in that cycle are ignored. After it, reads deliver words from location 0 onward.
- R8: Standard style, zero latency (`sel_rt_normal`=0): the word at location 0 is on `rd_data` right after the rewind edge. The next read delivers location 1.
- R9: Fall-through style, normal latency: `out_ready` is 0 for the two cycles after the rewind edge. It then returns to 1 with the word from location 0.
- R10: Fall-through style, zero latency: `out_ready` stays 1 and `rd_data` shows location 0 right after the rewind edge.
- R11: A rewind takes priority over a read at the same edge. That read does not change `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| mrst | input | 1 | Master reset, synchronous, active high; latches mode inputs |
| sel_fwft | input | 1 | Read style select at reset: 1 fall-through, 0 standard |
| sel_rt_normal | input | 1 | Rewind latency select at reset: 1 normal, 0 zero |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Read request |
| rewind | input | 1 | Retransmit strobe |
| rd_data | output | DATA_W | Read data register |
| empty | output | 1 | No word available for reading |
| out_ready | output | 1 | Fall-through style: valid word on rd_data |
| full | output | 1 | Memory holds DEPTH words |

## Verification
The hardest state to reach is a rewind issued mid-stream: part of a sequence has already been consumed, and a read request lands on the same edge as the rewind or in the recovery cycle. The stimulus fills the buffer with a distinct ramp and drains part of it. It then raises the strobe while the read request is still held, and keeps that request through the next cycle. Each mode is therefore entered through a fresh master reset with a different pair of select values. One further write after a zero-latency rewind shows that the write side kept its place.

// File: rtl/rewind_fifo_pkg.sv
package rewind_fifo_pkg;

    typedef enum logic {
        ST_RUN     = 1'b0,
        ST_RECOVER = 1'b1
    } rd_state_e;

    typedef struct packed {
        logic fwft;
        logic rt_normal;
    } mode_t;

endpackage

// File: rtl/rf_mode_latch.sv
module rf_mode_latch
    import rewind_fifo_pkg::*;
(
    input  logic  clk,
    input  logic  mrst,
    input  logic  sel_fwft,
    input  logic  sel_rt_normal,
    output mode_t mode
);

    always_ff @(posedge clk) begin
        if (mrst) begin
            mode.fwft      <= sel_fwft;
            mode.rt_normal <= sel_rt_normal;
        end
    end

    assert_mode_hold_R2: assert property (@(posedge clk) disable iff (mrst)
        1'b1 |=> $stable(mode));

endmodule

// File: rtl/rf_wr_ctrl.sv
module rf_wr_ctrl #(
    parameter int ADDR_W = 4,
    localparam int PTR_W = ADDR_W + 1
) (
    input  logic             clk,
    input  logic             mrst,
    input  logic             wr_en,
    input  logic             full,
    output logic             we,
    output logic [PTR_W-1:0] wptr
);

    assign we = wr_en && !full;

    always_ff @(posedge clk) begin
        if (mrst) begin
            wptr <= '0;
        end else if (we) begin
            wptr <= wptr + PTR_W'(1);
        end
    end

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (mrst)
        (wr_en && full) |=> $stable(wptr));

endmodule

// File: rtl/rf_storage.sv
module rf_storage #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/rf_rd_ctrl.sv
module rf_rd_ctrl
    import rewind_fifo_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4,
    localparam int PTR_W = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              mrst,
    input  mode_t             mode,
    input  logic              rd_en,
    input  logic              rewind,
    input  logic              occ_nz,
    input  logic              wptr_nz,
    input  logic [DATA_W-1:0] mem_q,
    output logic [ADDR_W-1:0] raddr,
    output logic [PTR_W-1:0]  rptr,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty,
    output logic              out_ready
);

    rd_state_e         state, state_n;
    logic [PTR_W-1:0]  rptr_n;
    logic [DATA_W-1:0] data_n;
    logic              valid, valid_n;

    assign raddr = rewind ? '0 : rptr[ADDR_W-1:0];

    // next-state and datapath decisions
    always_comb begin
        state_n = state;
        rptr_n  = rptr;
        data_n  = rd_data;
        valid_n = valid;
        if (rewind) begin
            if (mode.rt_normal) begin
                state_n = ST_RECOVER;
                rptr_n  = '0;
                valid_n = 1'b0;
            end else begin
                state_n = ST_RUN;
                if (wptr_nz) begin
                    rptr_n  = PTR_W'(1);
                    data_n  = mem_q;
                    valid_n = 1'b1;
                end else begin
                    rptr_n  = '0;
                    valid_n = 1'b0;
                end
            end
        end else begin
            unique case (state)
                ST_RECOVER: state_n = ST_RUN;
                ST_RUN: begin
                    if (mode.fwft) begin
                        if (!valid || rd_en) begin
                            if (occ_nz) begin
                                data_n  = mem_q;
                                rptr_n  = rptr + PTR_W'(1);
                                valid_n = 1'b1;
                            end else begin
                                valid_n = 1'b0;
                            end
                        end
                    end else if (rd_en && occ_nz) begin
                        data_n = mem_q;
                        rptr_n = rptr + PTR_W'(1);
                    end
                end
                default: state_n = ST_RUN;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (mrst) begin
            state   <= ST_RUN;
            rptr    <= '0;
            rd_data <= '0;
            valid   <= 1'b0;
        end else begin
            state   <= state_n;
            rptr    <= rptr_n;
            rd_data <= data_n;
            valid   <= valid_n;
        end
    end

    // flag outputs
    always_comb begin
        if (mode.fwft) begin
            empty     = !valid;
            out_ready = valid;
        end else begin
            empty     = (state == ST_RECOVER) || !occ_nz;
            out_ready = 1'b0;
        end
    end

    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (mrst)
        (!rewind && !occ_nz) |=> $stable(rptr));

    assert_rewind_home_R6: assert property (@(posedge clk) disable iff (mrst)
        (rewind && mode.rt_normal) |=> (rptr == '0 && state == ST_RECOVER));

    assert_std_recover_empty_R7: assert property (@(posedge clk) disable iff (mrst)
        (rewind && mode.rt_normal && !mode.fwft) |=> empty);

    assert_fwft_recover_R9: assert property (@(posedge clk) disable iff (mrst)
        (rewind && mode.rt_normal && mode.fwft) |=> !out_ready);

    assert_fwft_zero_ready_R10: assert property (@(posedge clk) disable iff (mrst)
        (rewind && !mode.rt_normal && mode.fwft && wptr_nz) |=> out_ready);

    assert_rewind_wins_R11: assert property (@(posedge clk) disable iff (mrst)
        (rewind && rd_en && mode.rt_normal) |=> $stable(rd_data));

endmodule

// File: rtl/rewind_fifo.sv
module rewind_fifo
    import rewind_fifo_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              mrst,
    input  logic              sel_fwft,
    input  logic              sel_rt_normal,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic              rewind,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty,
    output logic              out_ready,
    output logic              full
);

    localparam int PTR_W = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [PTR_W-1:0] FULL_CNT = PTR_W'(DEPTH);

    mode_t             mode;
    logic              we;
    logic [PTR_W-1:0]  wptr, rptr, occ;
    logic [ADDR_W-1:0] raddr;
    logic [DATA_W-1:0] mem_q;

    assign occ  = wptr - rptr;
    assign full = (occ == FULL_CNT);

    rf_mode_latch u_mode (
        .clk           (clk),
        .mrst          (mrst),
        .sel_fwft      (sel_fwft),
        .sel_rt_normal (sel_rt_normal),
        .mode          (mode)
    );

    rf_wr_ctrl #(.ADDR_W(ADDR_W)) u_wr (
        .clk   (clk),
        .mrst  (mrst),
        .wr_en (wr_en),
        .full  (full),
        .we    (we),
        .wptr  (wptr)
    );

    rf_storage #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
        .clk   (clk),
        .we    (we),
        .waddr (wptr[ADDR_W-1:0]),
        .wdata (wr_data),
        .raddr (raddr),
        .rdata (mem_q)
    );

    rf_rd_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
        .clk       (clk),
        .mrst      (mrst),
        .mode      (mode),
        .rd_en     (rd_en),
        .rewind    (rewind),
        .occ_nz    (occ != '0),
        .wptr_nz   (wptr != '0),
        .mem_q     (mem_q),
        .raddr     (raddr),
        .rptr      (rptr),
        .rd_data   (rd_data),
        .empty     (empty),
        .out_ready (out_ready)
    );

    assert_wptr_kept_R6: assert property (@(posedge clk) disable iff (mrst)
        (rewind && !wr_en) |=> $stable(wptr));

    assert_reset_flags_R1: assert property (@(posedge clk)
        mrst |=> (empty && !out_ready && !full));

endmodule

// File: tb/sim_rewind_fifo.sv
module sim_rewind_fifo;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          mrst, sel_fwft, sel_rt_normal;
    logic          wr_en, rd_en, rewind;
    logic [DW-1:0] wr_data;
    logic [DW-1:0] rd_data;
    logic          empty, out_ready, full;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rewind_fifo #(.DATA_W(DW), .ADDR_W(4)) u0 (
        .clk           (clk),
        .mrst          (mrst),
        .sel_fwft      (sel_fwft),
        .sel_rt_normal (sel_rt_normal),
        .wr_en         (wr_en),
        .wr_data       (wr_data),
        .rd_en         (rd_en),
        .rewind        (rewind),
        .rd_data       (rd_data),
        .empty         (empty),
        .out_ready     (out_ready),
        .full          (full)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic fw, input logic rtn);
        mrst = 1'b1; sel_fwft = fw; sel_rt_normal = rtn;
        wr_en = 1'b0; rd_en = 1'b0; rewind = 1'b0; wr_data = '0;
        step(); step();
        mrst = 1'b0;
    endtask

    task automatic push(input int base, input int n);
        for (int i = 0; i < n; i++) begin
            wr_en = 1'b1; wr_data = DW'(base + i);
            step();
        end
        wr_en = 1'b0;
    endtask

    task automatic test_reset_state();
        do_reset(1'b0, 1'b1);
        chk("R1 empty", empty, 1);
        chk("R1 full", full, 0);
        chk("R1 out_ready", out_ready, 0);
        chk("R1 rd_data", rd_data, 0);
    endtask

    task automatic test_fill_drain();
        do_reset(1'b0, 1'b1);
        push(8'hA0, 16);
        chk("R3 full at depth", full, 1);
        push(8'hFF, 1);
        for (int i = 0; i < 16; i++) begin
            rd_en = 1'b1; step();
            chk("R3 R4 read order", rd_data, 8'hA0 + i);
        end
        rd_en = 1'b0;
        chk("R4 empty after drain", empty, 1);
        chk("R3 full cleared", full, 0);
        rd_en = 1'b1; step(); rd_en = 1'b0;
        chk("R4 read while empty ignored", rd_data, 8'hAF);
    endtask

    task automatic test_std_normal();
        do_reset(1'b0, 1'b1);
        push(8'h10, 6);
        for (int i = 0; i < 3; i++) begin
            rd_en = 1'b1; step();
            chk("R4 partial read", rd_data, 8'h10 + i);
        end
        rewind = 1'b1; rd_en = 1'b1; step(); rewind = 1'b0;
        chk("R7 empty after rewind", empty, 1);
        chk("R11 rewind beats read", rd_data, 8'h12);
        step();
        chk("R7 read in recovery ignored", rd_data, 8'h12);
        chk("R7 empty recovers", empty, 0);
        for (int i = 0; i < 6; i++) begin
            step();
            chk("R6 replay from location 0", rd_data, 8'h10 + i);
        end
        rd_en = 1'b0;
        chk("R6 empty after replay", empty, 1);
    endtask

    task automatic test_std_zero();
        do_reset(1'b0, 1'b0);
        push(8'h30, 5);
        rd_en = 1'b1; step(); step(); rd_en = 1'b0;
        chk("R4 second word", rd_data, 8'h31);
        rewind = 1'b1; step(); rewind = 1'b0;
        chk("R8 location 0 at once", rd_data, 8'h30);
        chk("R8 not empty", empty, 0);
        push(8'h35, 1);
        for (int i = 1; i < 6; i++) begin
            rd_en = 1'b1; step();
            chk("R6 R8 continue after rewind", rd_data, 8'h30 + i);
        end
        rd_en = 1'b0;
        chk("R6 write pointer kept", empty, 1);
    endtask

    task automatic test_fwft_normal();
        do_reset(1'b1, 1'b1);
        chk("R1 fwft ready low", out_ready, 0);
        push(8'h50, 4);
        step();
        chk("R5 fall-through ready", out_ready, 1);
        chk("R5 head word", rd_data, 8'h50);
        rd_en = 1'b1; step();
        chk("R5 advance", rd_data, 8'h51);
        step(); rd_en = 1'b0;
        chk("R5 advance again", rd_data, 8'h52);
        rewind = 1'b1; step(); rewind = 1'b0;
        chk("R9 ready low cycle 1", out_ready, 0);
        step();
        chk("R9 ready low cycle 2", out_ready, 0);
        step();
        chk("R9 ready back", out_ready, 1);
        chk("R9 location 0", rd_data, 8'h50);
        rd_en = 1'b1;
        for (int i = 1; i < 4; i++) begin
            step();
            chk("R9 replay", rd_data, 8'h50 + i);
        end
        step(); rd_en = 1'b0;
        chk("R5 ready drops when drained", out_ready, 0);
    endtask

    task automatic test_fwft_zero();
        do_reset(1'b1, 1'b0);
        push(8'h70, 4);
        step();
        rd_en = 1'b1; step(); step(); rd_en = 1'b0;
        chk("R5 third word shown", rd_data, 8'h72);
        rewind = 1'b1; step(); rewind = 1'b0;
        chk("R10 ready held", out_ready, 1);
        chk("R10 location 0", rd_data, 8'h70);
        rd_en = 1'b1; step(); rd_en = 1'b0;
        chk("R10 next word", rd_data, 8'h71);
    endtask

    task automatic test_mode_latch();
        do_reset(1'b0, 1'b1);
        sel_fwft = 1'b1; sel_rt_normal = 1'b0;
        push(8'h99, 1);
        step();
        chk("R2 style unchanged ready", out_ready, 0);
        chk("R2 style unchanged data", rd_data, 0);
        chk("R2 style unchanged empty", empty, 0);
        rd_en = 1'b1; step(); rd_en = 1'b0;
        chk("R2 standard read", rd_data, 8'h99);
        rewind = 1'b1; step(); rewind = 1'b0;
        chk("R2 latency unchanged", empty, 1);
        chk("R2 no zero-latency load", rd_data, 8'h99);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        mrst = 1'b1; sel_fwft = 1'b0; sel_rt_normal = 1'b1;
        wr_en = 1'b0; rd_en = 1'b0; rewind = 1'b0; wr_data = '0;
        test_reset_state();
        test_fill_drain();
        test_std_normal();
        test_std_zero();
        test_fwft_normal();
        test_fwft_zero();
        test_mode_latch();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule